// File: doc/BRIEF.md
# Three-wire serial command loader

This block accepts command frames on three wires (a select, a serial clock and a data line) and turns them into display state. While the select line is high, each rising edge of the serial clock shifts one data bit into a frame register. The last three bits of a frame are a mode code. When the select line falls, a load strobe decodes that code and copies the bits just before it into the target. Segment frames update one or all three 56-bit grid segment latches. Brightness frames update the 10-bit brightness latch.

The three serial lines are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and its edges are found in the system clock domain. Frames can be longer than needed. Only the trailing bits count: 59 for a segment frame and 13 for a brightness frame.

Top module: `serial_cmd_loader`

## Requirements
- R1: Serial clock rising edges seen while the select line is low shift nothing, so a later load re-decodes the earlier frame contents.
- R2: In a segment frame the first data bit sent drives bit 0 (segment 1) of the addressed latch, and the 56th drives bit 55.
- R3: No latch changes while a frame is being shifted in. Latches update only after the select line falls, within 8 system clocks of the fall reaching the pins.
- R4: Mode code 000 writes the same 56 data bits into all three grid latches. The code is written as M0 M1 M2, M0 being the third-last bit sent.
- R5: Mode code 100 writes only grid latch 0, 010 only grid latch 1, and 110 only grid latch 2. The other latches keep their values.
- R6: Mode code 001 writes the brightness latch from the 10 bits before the mode bits, the first of them as LSB. The grid latches are not changed.
- R7: Mode codes 101, 011 and 111 change no latch.
- R8: After reset every latch reads 0.
- R9: Bits sent ahead of the trailing 59 (segment) or 13 (brightness) bits are discarded.
- R10: A serial clock rising edge that reaches the pins together with the select falling edge is still shifted in before the load decodes the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Frame select; a frame is open while high |
| sclk_i | input | 1 | Serial shift clock, idles high |
| sdat_i | input | 1 | Serial data, sampled on sclk_i rising |
| grid0_seg_o | output | 56 | Segment latch for grid 0 |
| grid1_seg_o | output | 56 | Segment latch for grid 1 |
| grid2_seg_o | output | 56 | Segment latch for grid 2 |
| bright_o | output | 10 | Brightness latch |

## Verification
Two actions can fall in the same system cycle: the shift of the last bit and the load of the frame. This happens when the final serial clock rise and the select fall arrive together. The bench provokes it by driving both lines in the same step, in directed frames and in about half of the random frames. It then checks that the decoded target and data include that last bit: a missing bit would shift the mode field by one position and select a different latch or corrupt the data.

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int SEG_W   = 56;
  localparam int DIM_W   = 10;
  localparam int MODE_W  = 3;
  localparam int GRIDS   = 3;
  localparam int FRAME_W = SEG_W + MODE_W;

  // mode code packed as {m2, m1, m0}
  typedef enum logic [MODE_W-1:0] {
    MODE_ALL = 3'b000,
    MODE_G0  = 3'b001,
    MODE_G1  = 3'b010,
    MODE_G2  = 3'b011,
    MODE_DIM = 3'b100
  } mode_e;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [STAGES-1:0] chain_q [N];

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= '0;
      else         chain_q[i] <= {chain_q[i][STAGES-2:0], async_i[i]};
    end
    assign sync_o[i] = chain_q[i][STAGES-1];
  end
endmodule

// File: rtl/scl_shifter.sv
module scl_shifter #(
  parameter int W = 59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] frame_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frame_o <= '0;
    else if (shift_i) frame_o <= {frame_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/scl_loader.sv
module scl_loader
  import scl_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int DW = DIM_W,
  parameter int MW = MODE_W,
  parameter int NG = GRIDS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  load_i,
  input  logic [SW+MW-1:0]      frame_i,
  output logic [NG-1:0][SW-1:0] grid_o,
  output logic [DW-1:0]         dim_o
);
  localparam int FW = SW + MW;

  logic          load_q;
  logic [MW-1:0] code;
  logic [SW-1:0] seg_data;
  logic [DW-1:0] dim_data;

  // newest bit sits at frame_i[0]: it is m2
  always_comb begin
    for (int m = 0; m < MW; m++) code[m] = frame_i[MW-1-m];
    for (int k = 0; k < SW; k++) seg_data[k] = frame_i[FW-1-k];
    for (int k = 0; k < DW; k++) dim_data[k] = frame_i[DW+MW-1-k];
  end

  // one cycle of slack lets a coincident final shift land first
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) load_q <= 1'b0;
    else         load_q <= load_i;
  end

  for (genvar g = 0; g < NG; g++) begin : g_grid
    logic wr_en;
    assign wr_en = load_q && (code == MODE_ALL || code == MW'(g + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    grid_o[g] <= '0;
      else if (wr_en) grid_o[g] <= seg_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          dim_o <= '0;
    else if (load_q && code == MODE_DIM)  dim_o <= dim_data;
  end

  assert_no_undef_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_q && code > MODE_DIM) |=> ($stable(grid_o) && $stable(dim_o)));

  assert_broadcast_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_q && code == MODE_ALL) |=> (grid_o[0] == grid_o[1] && grid_o[1] == grid_o[2]));

  assert_single_grid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_q && code == MODE_G0) |=> ($stable(grid_o[1]) && $stable(grid_o[2]) && $stable(dim_o)));

  assert_dim_keeps_grids_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_q && code == MODE_DIM) |=> $stable(grid_o));

  assert_load_only_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_q |=> ($stable(grid_o) && $stable(dim_o)));
endmodule

// File: rtl/serial_cmd_loader.sv
module serial_cmd_loader
  import scl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             sclk_i,
  input  logic             sdat_i,
  output logic [SEG_W-1:0] grid0_seg_o,
  output logic [SEG_W-1:0] grid1_seg_o,
  output logic [SEG_W-1:0] grid2_seg_o,
  output logic [DIM_W-1:0] bright_o
);
  logic [2:0]               line_s;
  logic                     sel_s, sclk_s, dat_s;
  logic                     sel_p, sclk_p;
  logic                     shift_en, load_stb;
  logic [FRAME_W-1:0]       frame;
  logic [GRIDS-1:0][SEG_W-1:0] grids;

  scl_sync #(.N(3), .STAGES(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sdat_i, sclk_i, sel_i}),
    .sync_o  (line_s)
  );

  assign {dat_s, sclk_s, sel_s} = line_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_p  <= 1'b0;
      sclk_p <= 1'b1;
    end else begin
      sel_p  <= sel_s;
      sclk_p <= sclk_s;
    end
  end

  // select judged one cycle late so a rise coincident with its fall counts
  assign shift_en = sclk_s && !sclk_p && sel_p;
  assign load_stb = sel_p && !sel_s;

  scl_shifter #(.W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_en),
    .bit_i   (dat_s),
    .frame_o (frame)
  );

  scl_loader #(.SW(SEG_W), .DW(DIM_W), .MW(MODE_W), .NG(GRIDS)) u_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_stb),
    .frame_i (frame),
    .grid_o  (grids),
    .dim_o   (bright_o)
  );

  assign grid0_seg_o = grids[0];
  assign grid1_seg_o = grids[1];
  assign grid2_seg_o = grids[2];

  assert_no_shift_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_p |=> $stable(frame));

  assert_frame_moves_on_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en |=> (frame[0] == $past(dat_s)));
endmodule

// File: tb/serial_cmd_loader_bench.sv
module serial_cmd_loader_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, sclk = 1'b1, sdat = 1'b0;
  logic [55:0] g0, g1, g2;
  logic [9:0]  br;
  logic [55:0] e_g0 = '0, e_g1 = '0, e_g2 = '0;
  logic [9:0]  e_br = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_cmd_loader u_serial_cmd_loader (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .sclk_i(sclk), .sdat_i(sdat),
    .grid0_seg_o(g0), .grid1_seg_o(g1), .grid2_seg_o(g2), .bright_o(br)
  );

  task automatic check(input string req, input string what, input logic [55:0] got, input logic [55:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "grid0", g0, e_g0);
    check(req, "grid1", g1, e_g1);
    check(req, "grid2", g2, e_g2);
    check(req, "bright", {46'd0, br}, {46'd0, e_br});
  endtask

  function automatic logic [55:0] seg_of(input logic [127:0] b, input int n);
    logic [55:0] r;
    for (int k = 0; k < 56; k++) r[k] = b[n-59+k];
    return r;
  endfunction

  function automatic logic [9:0] dim_of(input logic [127:0] b, input int n);
    logic [9:0] r;
    for (int k = 0; k < 10; k++) r[k] = b[n-13+k];
    return r;
  endfunction

  // model: code packed {m2,m1,m0}
  task automatic model(input logic [127:0] b, input int n);
    logic [2:0] code;
    code = {b[n-1], b[n-2], b[n-3]};
    case (code)
      3'b000: begin e_g0 = seg_of(b, n); e_g1 = seg_of(b, n); e_g2 = seg_of(b, n); end
      3'b001: e_g0 = seg_of(b, n);
      3'b010: e_g1 = seg_of(b, n);
      3'b011: e_g2 = seg_of(b, n);
      3'b100: e_br = dim_of(b, n);
      default: ;
    endcase
  endtask

  task automatic send(input logic [127:0] b, input int n, input bit merge, input bit mid_chk, input string req);
    sel = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sdat = b[i];
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      if (i == n - 1 && merge) sel = 1'b0;
      repeat (4) @(negedge clk);
    end
    if (mid_chk) begin
      repeat (6) @(negedge clk);
      check_all("R3 mid-frame");
    end
    sel = 1'b0;
    repeat (10) @(negedge clk);
    model(b, n);
    check_all(req);
  endtask

  function automatic logic [127:0] build(input logic [127:0] body, input int n, input logic [2:0] code);
    logic [127:0] r;
    r = body;
    r[n-3] = code[0];
    r[n-2] = code[1];
    r[n-1] = code[2];
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] b;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_all("R8 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R8 after release");

    // R4 broadcast, with R3 mid-frame hold
    b = build({72'd0, 56'hFF_FFFF_FFFF_FFFF}, 59, 3'b000);
    send(b, 59, 1'b0, 1'b1, "R4 broadcast ones");
    // R2 order: only first bit set, into grid latch 1 (M0M1M2=010)
    b = build({127'd0, 1'b1}, 59, 3'b010);
    send(b, 59, 1'b0, 1'b0, "R2 first bit to seg 1");
    check("R2", "grid1 bit0", g1, 56'h1);
    b = build({72'd0, 1'b1, 55'd0}, 59, 3'b001);
    send(b, 59, 1'b0, 1'b0, "R2 last bit to seg 56");
    // R5 grid 2 only (M0M1M2=110)
    b = build({72'd0, 56'h12_3456_789A_BCDE}, 59, 3'b011);
    send(b, 59, 1'b0, 1'b0, "R5 grid2 only");
    // R6 brightness
    b = build({118'd0, 10'h3FF}, 13, 3'b100);
    send(b, 13, 1'b0, 1'b0, "R6 bright max");
    b = build({118'd0, 10'h001}, 13, 3'b100);
    send(b, 13, 1'b0, 1'b0, "R6 bright lsb");
    check("R6", "lsb", {46'd0, br}, 56'h1);
    // R7 undefined codes
    b = build({72'd0, 56'hA5A5_A5A5_A5A5_A5}, 59, 3'b101);
    send(b, 59, 1'b0, 1'b0, "R7 undefined 101");
    b = build({72'd0, 56'h5A5A_5A5A_5A5A_5A}, 59, 3'b111);
    send(b, 59, 1'b0, 1'b0, "R7 undefined 111");
    // R10 coincident last rise and select fall
    b = build({72'd0, 56'h0F0F_0F0F_0F0F_0F}, 59, 3'b001);
    send(b, 59, 1'b1, 1'b0, "R10 coincident edge");
    // R9 leading junk
    b = build({64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0000_1234}, 66, 3'b000);
    send(b, 66, 1'b0, 1'b0, "R9 junk prefix seg");
    b = build({100'd0, 28'hABC_DE57}, 20, 3'b100);
    send(b, 20, 1'b0, 1'b0, "R9 junk prefix dim");

    // R1: clocks with select low must not enter the frame register
    sel = 1'b0;
    for (int i = 0; i < 62; i++) begin
      sdat = (i < 59);
      sclk = 1'b0; repeat (4) @(negedge clk);
      sclk = 1'b1; repeat (4) @(negedge clk);
    end
    sel = 1'b1; repeat (6) @(negedge clk);
    sel = 1'b0; repeat (10) @(negedge clk);
    check_all("R1 idle clocks ignored");

    for (int t = 0; t < 40; t++) begin
      int kind, pre, n;
      logic [2:0] code;
      b = {$urandom, $urandom, $urandom, $urandom};
      kind = $urandom % 6;
      pre = (($urandom % 4) == 0) ? int'($urandom % 4) : 0;
      case (kind)
        0: code = 3'b000;
        1: code = 3'b001;
        2: code = 3'b010;
        3: code = 3'b011;
        4: code = 3'b100;
        default: code = 3'b101 + 3'($urandom % 3);
      endcase
      n = ((kind == 4) ? 13 : 59) + pre;
      b = build(b, n, code);
      send(b, n, 1'($urandom % 2), 1'b0, "R4/R5/R6/R7/R9 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule